// File: doc/BRIEF.md
# Vector Lane Load/Store Instruction Decoder

This block decodes the 32-bit instruction class that moves one vector lane, or one element replicated across a whole register, between memory and one to four consecutive vector registers. An instruction word comes in with a valid bit. The block reports whether the word belongs to the class at all, and whether the encoding is allowed. It also reports the direction, the addressing form, and whether the access replicates. For the element, it gives the width, the lane number, the structure count, the full/half register width bit and the three register numbers.

The lane index and the element width are not plain fields. Both come from a remapping of the Q, S and size bits that depends on the opcode, and that remapping has its own forbidden combinations. The decode result is captured in an output register one clock after a valid word is seen. The register holds its value while no valid word arrives. A word outside the class raises a separate no-match output and does not raise the illegal flag. When the illegal flag is set, the other decoded fields carry no meaning.

Top module: `simd_lane_ldst_dec`

## Requirements
- R1: `out_vld` is high exactly in the clock after `in_vld` was high and is low after reset. The decoded outputs change only in the clock after a valid word and otherwise hold their value.
- R2: A word is in the class only when bit 31 is 0 and bits 29:24 equal 001101. Any other word gives `out_nomatch`=1 and `out_illegal`=0.
- R3: Register numbers are taken from these bits: `out_rt` from bits 4:0, `out_rn` from 9:5 and `out_rm` from 20:16. `out_q` comes from bit 30, `out_post` from bit 23 and `out_load` from bit 22.
- R4: `out_count` equals {bit 13, bit 21} + 1, which gives 1 to 4 registers.
- R5: When bits 15:14 = 00, the element is a byte (`out_scale`=0). The lane is {Q, S=bit 12, size=bits 11:10}.
- R6: When bits 15:14 = 01, the element is a halfword (`out_scale`=1). size[0]=1 is illegal. The lane is {0, Q, S, size[1]}.
- R7: When bits 15:14 = 10, size[1]=1 is illegal. With size=00 the element is a word (`out_scale`=2) and the lane is {00, Q, S}. With size=01 the element is a doubleword (`out_scale`=3) and the lane is {000, Q}; in this case S=1 is illegal.
- R8: When bits 15:14 = 11, `out_repl`=1 and `out_scale` equals size. The form is illegal for a store (bit 22=0) or when S=1.
- R9: When `out_post`=0, any nonzero Rm is illegal. When `out_post`=1, any Rm value is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Instruction word is valid this cycle |
| in_word | input | 32 | Instruction word |
| out_vld | output | 1 | Registered decode is new this cycle |
| out_nomatch | output | 1 | Word is not in this instruction class |
| out_illegal | output | 1 | In class but unallocated encoding |
| out_load | output | 1 | 1 = load, 0 = store |
| out_post | output | 1 | Post-index addressing |
| out_repl | output | 1 | Load and replicate to all lanes |
| out_scale | output | 2 | Element size: 0 byte, 1 half, 2 word, 3 double |
| out_count | output | 3 | Number of registers, 1 to 4 |
| out_lane | output | 4 | Lane index (0 for replicate) |
| out_q | output | 1 | Full-width register flag |
| out_rt | output | 5 | First transfer register |
| out_rn | output | 5 | Base register |
| out_rm | output | 5 | Post-index offset register |

## Verification
The datapath is a single register stage after combinational logic, so any wrong decode shows on the output pins in the very next clock after the word's valid cycle. A mistake in the size-dependent remapping shows up in three possible ways: a lane number shifted by one position, a scale that stays at word instead of changing to double, or an illegal flag that fails to rise for a forbidden size or S combination. A load enable that ignores `in_vld` shows up as outputs that change during idle cycles, while the inputs present a different word.

// File: rtl/simd_ls_pkg.sv
package simd_ls_pkg;
   localparam int RNUM_W = 5;
   localparam int LANE_W = 4;
   localparam int CNT_W  = 3;

   typedef enum logic [1:0] {
      ESZ_B = 2'd0,
      ESZ_H = 2'd1,
      ESZ_W = 2'd2,
      ESZ_D = 2'd3
   } esz_e;

   typedef struct packed {
      logic              nomatch;
      logic              illegal;
      logic              load;
      logic              post;
      logic              repl;
      esz_e              esz;
      logic [CNT_W-1:0]  nstruct;
      logic [LANE_W-1:0] lane;
      logic              q;
      logic [RNUM_W-1:0] rt;
      logic [RNUM_W-1:0] rn;
      logic [RNUM_W-1:0] rm;
   } dec_t;
endpackage

// File: rtl/simd_ls_fields.sv
module simd_ls_fields
   import simd_ls_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic [INSN_W-1:0] word_i,
   output logic              hit_o,
   output logic              q_o,
   output logic              post_o,
   output logic              load_o,
   output logic              rsel_o,
   output logic [2:0]        opc_o,
   output logic              s_o,
   output logic [1:0]        size_o,
   output logic [RNUM_W-1:0] rt_o,
   output logic [RNUM_W-1:0] rn_o,
   output logic [RNUM_W-1:0] rm_o
);
   localparam int         CLS_LO   = 24;
   localparam int         CLS_HI   = 29;
   localparam logic [5:0] CLS_CODE = 6'b001101;
   localparam int         RT_LO    = 0;
   localparam int         RN_LO    = 5;
   localparam int         RM_LO    = 16;

   assign hit_o  = !word_i[31] && (word_i[CLS_HI:CLS_LO] == CLS_CODE);
   assign q_o    = word_i[30];
   assign post_o = word_i[23];
   assign load_o = word_i[22];
   assign rsel_o = word_i[21];
   assign opc_o  = word_i[15:13];
   assign s_o    = word_i[12];
   assign size_o = word_i[11:10];
   assign rt_o   = word_i[RT_LO +: RNUM_W];
   assign rn_o   = word_i[RN_LO +: RNUM_W];
   assign rm_o   = word_i[RM_LO +: RNUM_W];
endmodule

// File: rtl/simd_ls_lane_map.sv
module simd_ls_lane_map
   import simd_ls_pkg::*;
(
   input  logic [1:0]        base_i,
   input  logic              q_i,
   input  logic              s_i,
   input  logic [1:0]        size_i,
   input  logic              load_i,
   output esz_e              esz_o,
   output logic [LANE_W-1:0] lane_o,
   output logic              repl_o,
   output logic              bad_o
);
   always_comb begin
      esz_o  = ESZ_B;
      lane_o = '0;
      repl_o = 1'b0;
      bad_o  = 1'b0;
      unique case (base_i)
         2'd0: begin
            lane_o = {q_i, s_i, size_i};
         end
         2'd1: begin
            esz_o  = ESZ_H;
            lane_o = {1'b0, q_i, s_i, size_i[1]};
            bad_o  = size_i[0];
         end
         2'd2: begin
            if (size_i[0]) begin
               esz_o  = ESZ_D;
               lane_o = {3'b000, q_i};
               bad_o  = size_i[1] | s_i;
            end else begin
               esz_o  = ESZ_W;
               lane_o = {2'b00, q_i, s_i};
               bad_o  = size_i[1];
            end
         end
         default: begin
            repl_o = 1'b1;
            esz_o  = esz_e'(size_i);
            bad_o  = !load_i | s_i;
         end
      endcase
   end
endmodule

// File: rtl/simd_lane_ldst_dec.sv
module simd_lane_ldst_dec
   import simd_ls_pkg::*;
#(
   parameter int INSN_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [INSN_W-1:0] in_word,
   output logic              out_vld,
   output logic              out_nomatch,
   output logic              out_illegal,
   output logic              out_load,
   output logic              out_post,
   output logic              out_repl,
   output logic [1:0]        out_scale,
   output logic [CNT_W-1:0]  out_count,
   output logic [LANE_W-1:0] out_lane,
   output logic              out_q,
   output logic [RNUM_W-1:0] out_rt,
   output logic [RNUM_W-1:0] out_rn,
   output logic [RNUM_W-1:0] out_rm
);
   if (INSN_W != 32) begin : g_bad_width
      $error("simd_lane_ldst_dec: INSN_W must be 32");
   end

   logic              hit, q, post, load, rsel, s, repl, lane_bad;
   logic [2:0]        opc;
   logic [1:0]        size;
   logic [RNUM_W-1:0] rt, rn, rm;
   logic [LANE_W-1:0] lane;
   esz_e              esz;
   dec_t              dec_c, dec_q;
   logic              vld_q;

   simd_ls_fields #(.INSN_W(INSN_W)) u_fields (
      .word_i (in_word),
      .hit_o  (hit),
      .q_o    (q),
      .post_o (post),
      .load_o (load),
      .rsel_o (rsel),
      .opc_o  (opc),
      .s_o    (s),
      .size_o (size),
      .rt_o   (rt),
      .rn_o   (rn),
      .rm_o   (rm)
   );

   simd_ls_lane_map u_lane (
      .base_i (opc[2:1]),
      .q_i    (q),
      .s_i    (s),
      .size_i (size),
      .load_i (load),
      .esz_o  (esz),
      .lane_o (lane),
      .repl_o (repl),
      .bad_o  (lane_bad)
   );

   always_comb begin
      dec_c         = '0;
      dec_c.nomatch = !hit;
      dec_c.illegal = hit && (lane_bad || (!post && (rm != '0)));
      dec_c.load    = load;
      dec_c.post    = post;
      dec_c.repl    = repl;
      dec_c.esz     = esz;
      dec_c.nstruct = {1'b0, opc[0], rsel} + CNT_W'(1);
      dec_c.lane    = lane;
      dec_c.q       = q;
      dec_c.rt      = rt;
      dec_c.rn      = rn;
      dec_c.rm      = rm;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dec_q <= '0;
         end else begin
            vld_q <= in_vld;
            if (in_vld) dec_q <= dec_c;
         end
      end

      // R1: valid is delayed by exactly one clock
      a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);
      a_r1_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> !out_vld);
      // R1: decoded fields hold while no valid word arrives
      a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> $stable(out_rt) && $stable(out_lane) && $stable(out_illegal));
   end else begin : g_comb
      assign vld_q = in_vld;
      assign dec_q = dec_c;
   end

   assign out_vld     = vld_q;
   assign out_nomatch = dec_q.nomatch;
   assign out_illegal = dec_q.illegal;
   assign out_load    = dec_q.load;
   assign out_post    = dec_q.post;
   assign out_repl    = dec_q.repl;
   assign out_scale   = dec_q.esz;
   assign out_count   = dec_q.nstruct;
   assign out_lane    = dec_q.lane;
   assign out_q       = dec_q.q;
   assign out_rt      = dec_q.rt;
   assign out_rn      = dec_q.rn;
   assign out_rm      = dec_q.rm;

   // R2: no-match never coexists with illegal
   a_r2_nomatch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !(out_nomatch && out_illegal));
   // R8: an accepted replicate form is always a load
   a_r8_repl_is_load: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_nomatch && !out_illegal && out_repl) |-> out_load);
   // R9: accepted non-post-index forms carry Rm of zero
   a_r9_rm_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_nomatch && !out_illegal && !out_post) |-> (out_rm == '0));
   // R7: an accepted doubleword lane never exceeds one bit
   a_r7_dword_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_nomatch && !out_illegal && !out_repl && out_scale == 2'd3)
      |-> (out_lane[3:1] == 3'b000));
endmodule

// File: tb/sim_simd_lane_ldst_dec.sv
module sim_simd_lane_ldst_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_vld, out_nomatch, out_illegal, out_load, out_post, out_repl, out_q;
   logic [1:0]  out_scale;
   logic [2:0]  out_count;
   logic [3:0]  out_lane;
   logic [4:0]  out_rt, out_rn, out_rm;

   int total = 0;
   int bad   = 0;

   typedef struct {
      string       tag;
      logic        nomatch, illegal, load, post, repl, q;
      logic [1:0]  scale;
      logic [2:0]  count;
      logic [3:0]  lane;
      logic [4:0]  rt, rn, rm;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   simd_lane_ldst_dec u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
      .out_vld(out_vld), .out_nomatch(out_nomatch), .out_illegal(out_illegal),
      .out_load(out_load), .out_post(out_post), .out_repl(out_repl),
      .out_scale(out_scale), .out_count(out_count), .out_lane(out_lane),
      .out_q(out_q), .out_rt(out_rt), .out_rn(out_rn), .out_rm(out_rm)
   );

   function automatic logic [31:0] mk(logic q, logic post, logic load, logic r,
                                      logic [4:0] rm, logic [2:0] opc, logic s,
                                      logic [1:0] size, logic [4:0] rn, logic [4:0] rt);
      return {1'b0, q, 6'b001101, post, load, r, rm, opc, s, size, rn, rt};
   endfunction

   function automatic exp_t model(string tag, logic [31:0] w);
      exp_t e;
      logic [1:0] sz;
      e.tag = tag;
      e.nomatch = w[31] || (w[29:24] != 6'b001101);
      e.q = w[30]; e.post = w[23]; e.load = w[22];
      e.rt = w[4:0]; e.rn = w[9:5]; e.rm = w[20:16];
      e.count = {1'b0, w[13], w[21]} + 3'd1;
      sz = w[11:10];
      e.repl = 1'b0; e.lane = '0; e.illegal = 1'b0; e.scale = 2'd0;
      case (w[15:14])
         2'b00: e.lane = {w[30], w[12], sz};
         2'b01: begin e.scale = 2'd1; e.illegal = sz[0]; e.lane = {1'b0, w[30], w[12], sz[1]}; end
         2'b10: begin
            if (sz == 2'b01) begin e.scale = 2'd3; e.lane = {3'b0, w[30]}; e.illegal = w[12]; end
            else begin e.scale = 2'd2; e.lane = {2'b0, w[30], w[12]}; e.illegal = sz[1]; end
         end
         default: begin e.repl = 1'b1; e.scale = sz; e.illegal = !w[22] || w[12]; end
      endcase
      if (!w[23] && w[20:16] != 5'd0) e.illegal = 1'b1;
      if (e.nomatch) e.illegal = 1'b0;
      return e;
   endfunction

   task automatic chk(string tag, string fld, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, fld, got, exp);
      end
   endtask

   task automatic drive(string tag, logic [31:0] w);
      @(negedge clk);
      in_vld  = 1'b1;
      in_word = w;
      sb.push_back(model(tag, w));
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (sb.size() == 0) begin
            chk("R1", "unexpected out_vld", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "nomatch", out_nomatch, e.nomatch);
            chk(e.tag, "illegal", out_illegal, e.illegal);
            if (!e.nomatch && !e.illegal) begin
               chk(e.tag, "load", out_load, e.load);
               chk(e.tag, "post", out_post, e.post);
               chk(e.tag, "repl", out_repl, e.repl);
               chk(e.tag, "scale", out_scale, e.scale);
               chk(e.tag, "count", out_count, e.count);
               chk(e.tag, "q", out_q, e.q);
               chk(e.tag, "rt", out_rt, e.rt);
               chk(e.tag, "rn", out_rn, e.rn);
               chk(e.tag, "rm", out_rm, e.rm);
               if (!e.repl) chk(e.tag, "lane", out_lane, e.lane);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset out_vld", out_vld, 1'b0);

      // R3 field positions, byte store pre-index
      drive("R3", mk(1, 0, 0, 0, 5'd0, 3'b000, 0, 2'b10, 5'd9, 5'd3));
      drive("R3", mk(0, 1, 1, 0, 5'd30, 3'b000, 1, 2'b01, 5'd31, 5'd28));
      // R4 structure counts
      drive("R4", mk(0, 0, 1, 1, 5'd0, 3'b000, 0, 2'b00, 5'd1, 5'd2));
      drive("R4", mk(0, 0, 1, 0, 5'd0, 3'b001, 0, 2'b00, 5'd1, 5'd2));
      drive("R4", mk(0, 0, 1, 1, 5'd0, 3'b001, 0, 2'b00, 5'd1, 5'd2));
      // R5 byte lanes
      drive("R5", mk(1, 0, 1, 0, 5'd0, 3'b000, 0, 2'b10, 5'd4, 5'd6));
      drive("R5", mk(1, 0, 0, 0, 5'd0, 3'b000, 1, 2'b11, 5'd4, 5'd6));
      // R6 halfword
      drive("R6", mk(1, 0, 1, 0, 5'd0, 3'b010, 1, 2'b10, 5'd7, 5'd8));
      drive("R6", mk(0, 0, 1, 0, 5'd0, 3'b010, 0, 2'b01, 5'd7, 5'd8));
      // R7 word and doubleword
      drive("R7", mk(1, 0, 0, 0, 5'd0, 3'b100, 1, 2'b00, 5'd2, 5'd11));
      drive("R7", mk(1, 0, 0, 0, 5'd0, 3'b100, 0, 2'b10, 5'd2, 5'd11));
      drive("R7", mk(1, 0, 1, 1, 5'd0, 3'b101, 0, 2'b01, 5'd2, 5'd11));
      drive("R7", mk(1, 0, 1, 0, 5'd0, 3'b100, 1, 2'b01, 5'd2, 5'd11));
      // R8 replicate
      drive("R8", mk(1, 1, 1, 1, 5'd31, 3'b111, 0, 2'b11, 5'd12, 5'd31));
      drive("R8", mk(0, 0, 1, 0, 5'd0, 3'b110, 0, 2'b01, 5'd12, 5'd13));
      drive("R8", mk(0, 0, 0, 0, 5'd0, 3'b110, 0, 2'b01, 5'd12, 5'd13));
      drive("R8", mk(0, 0, 1, 0, 5'd0, 3'b110, 1, 2'b00, 5'd12, 5'd13));
      // R9 Rm rule
      drive("R9", mk(0, 0, 1, 0, 5'd5, 3'b000, 0, 2'b00, 5'd3, 5'd3));
      drive("R9", mk(0, 1, 1, 0, 5'd5, 3'b000, 0, 2'b00, 5'd3, 5'd3));
      // R2 class match
      drive("R2", mk(0, 0, 1, 0, 5'd0, 3'b000, 0, 2'b00, 5'd3, 5'd3) | 32'h8000_0000);
      drive("R2", mk(0, 0, 1, 0, 5'd0, 3'b000, 0, 2'b00, 5'd3, 5'd3) ^ 32'h0100_0000);
      // R1 hold: last legal decode then idle with a different word
      drive("R1", mk(0, 0, 1, 0, 5'd0, 3'b000, 0, 2'b00, 5'd4, 5'd17));
      @(negedge clk);
      in_vld  = 1'b0;
      in_word = mk(1, 0, 1, 0, 5'd0, 3'b000, 0, 2'b00, 5'd4, 5'd2);
      repeat (2) @(negedge clk);
      chk("R1", "idle out_vld", out_vld, 1'b0);
      chk("R1", "hold rt", out_rt, 5'd17);
      chk("R1", "scoreboard drained", sb.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule